// File: doc/BRIEF.md
# SPI Slave Register Access Engine

This block is an SPI mode-0 slave that carries a short three-phase protocol over a byte-wide shift register. Each transaction starts with a command byte, then an address byte, then any number of data bytes. The command byte carries three things: a transfer direction, a memory-space flag and a 6-bit byte count. The address byte picks one of two byte-addressable objects. The first is a read-only object whose bytes come from an input port. The second is a small writable array held inside the block. Data bytes are moved from the highest offset down to offset zero.

A single shift register both receives and transmits, so the master sees each reply one frame late. After a valid command the slave loads the acknowledge byte 0xCC, and after an address it loads 0xBB. During a read the master polls with 0x00 to clock out each byte. A bank access time is modelled as a load that lands a fixed number of clock cycles after the frame ends. If the bit counter is already moving at that moment, the load is refused and a collision flag is raised. If no frame arrives within a programmable number of clock cycles, the next frame is treated as a command.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset `miso`, `frame_done`, `xfer_flag`, `wr_coll` and `cmd_nv` are all 0, and the protocol is in the command phase.
- R2: Bits are shifted in and out MSB first, in SPI mode 0: MOSI is sampled on the rising SCLK edge and the shifter advances on the falling edge. In the command phase, a received byte of 0x00 is ignored, the phase stays command and nothing is loaded. When nothing is loaded, the next frame transmits the byte just received.
- R3: A nonzero command byte is decoded as follows: bit 6 = 1 selects write and 0 selects read, and bits 5:0 give the byte count. The next frame transmits 0xCC and the protocol moves to the address phase.
- R4: The byte received in the address phase is stored as the target. The next frame transmits 0xBB and the protocol enters the data phase.
- R5: In a read, each data frame decrements the count and loads the byte at offset (count after decrement). Bytes therefore leave from the highest offset down to 0. Address 0x01 is read-only, and its byte i is `ro_data[8i+7:8i]`. Address 0x04 is the writable array.
- R6: In a write, each data frame decrements the count and stores the received byte at offset (count after decrement) of the array at 0x04. Reading back returns the stored bytes.
- R7: A data frame that arrives with the count already at zero is consumed without effect and returns the protocol to the command phase. This includes the first data frame after a command with count 0.
- R8: A read from an unknown address, or beyond an object's size, transmits 0x00. A write to 0x01, to an unknown address, or beyond the array is discarded.
- R9: If at least `IDLE_CYC` clock cycles pass between two frame ends, the later frame is decoded as a command, whatever the phase was.
- R10: A transmit load that falls while the bit counter is nonzero, or on a falling SCLK edge, sets `wr_coll` and leaves the shift register unchanged.
- R11: `xfer_flag` is set at every frame end and stays set until a successful load. A successful load clears both `xfer_flag` and `wr_coll`.
- R12: `cmd_nv` holds bit 7 of the last accepted command byte.
- R13: `frame_done` is a single-cycle pulse, given once for each completed 8-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Slave select, active low; high clears the bit counter |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master (MSB of the shift register) |
| ro_data | input | 8*RO_BYTES | Bytes of the read-only object at address 0x01 |
| frame_done | output | 1 | One-cycle pulse at each frame end |
| xfer_flag | output | 1 | Frame complete and not yet followed by a load |
| wr_coll | output | 1 | Last load attempt collided with a frame in progress |
| cmd_nv | output | 1 | Memory-space bit of the last accepted command |

## Verification
The bench targets four kinds of corner case:
- **Data-phase edges.** It sends a command with count zero, polls one byte past the end of a read, and writes more bytes than the array holds. A design that skips the consumed frame would take the next poll as a command. A design that forgets to decrement first would return bytes shifted by one offset. A design that writes out of range would corrupt the array, and the read-back would show it.
- **Ignored or discarded input.** It sends 0x00 polls in the command phase and writes to the read-only object. A design that acknowledges 0x00 returns 0xCC instead of the echoed 0x00. A design that honours the write changes the read-only bytes on read-back.
- **Idle timeout.** It parks the slave in the data phase and waits past the timeout. A design without the timeout treats the next command as data and never acknowledges it.
- **Load collision.** It clocks two frames back to back at full rate, so the acknowledge load lands mid-frame. A design that ignores the collision rule leaves `wr_coll` low, or never clears it on the next clean load.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int          RW_BYTES = 8,
  parameter int          RO_BYTES = 4,
  parameter logic [7:0]  RW_ADDR  = 8'h04,
  parameter logic [7:0]  RO_ADDR  = 8'h01,
  parameter int          LOAD_DLY = 4,
  parameter int          IDLE_CYC = 200_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [8*RO_BYTES-1:0] ro_data,
  output logic                  frame_done,
  output logic                  xfer_flag,
  output logic                  wr_coll,
  output logic                  cmd_nv
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int LW = $clog2(LOAD_DLY + 1);

  typedef enum logic [1:0] {S_CMD, S_ADDR, S_DATA} phase_t;

  logic         sclk_q, bit_in;
  logic [7:0]   sr;
  logic [2:0]   bitcnt;
  phase_t       st, eff;
  logic [5:0]   cnt, cnt_m1;
  logic         rd;
  logic [7:0]   tgt;
  logic [IW-1:0] idle;
  logic [LW-1:0] ldc;
  logic [7:0]   ld_val, rd_byte;
  logic [7:0]   mem [RW_BYTES];

  wire rise    = !cs_n &&  sclk && !sclk_q;
  wire fall    = !cs_n && !sclk &&  sclk_q;
  wire tmo     = (idle >= IW'(IDLE_CYC));
  wire ld_fire = (ldc == LW'(1));
  wire busy    = (bitcnt != 3'd0) || fall;

  assign eff    = tmo ? S_CMD : st;
  assign cnt_m1 = cnt - 6'd1;
  assign miso   = sr[7];

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < RO_BYTES; i++)
      if (tgt == RO_ADDR && cnt_m1 == 6'(i)) rd_byte = ro_data[i*8 +: 8];
    for (int i = 0; i < RW_BYTES; i++)
      if (tgt == RW_ADDR && cnt_m1 == 6'(i)) rd_byte = mem[i];
  end

  // serial front end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      bit_in     <= 1'b0;
      bitcnt     <= 3'd0;
      sr         <= 8'h00;
      frame_done <= 1'b0;
      xfer_flag  <= 1'b0;
      wr_coll    <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      frame_done <= fall && (bitcnt == 3'd7);
      if (rise) bit_in <= mosi;
      if (cs_n) bitcnt <= 3'd0;
      else if (fall) bitcnt <= bitcnt + 3'd1;
      if (fall) sr <= {sr[6:0], bit_in};
      if (ld_fire) begin
        if (busy) wr_coll <= 1'b1;
        else begin
          sr        <= ld_val;
          wr_coll   <= 1'b0;
          xfer_flag <= 1'b0;
        end
      end
      if (frame_done) xfer_flag <= 1'b1;
    end
  end

  // protocol engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CMD;
      cnt    <= 6'd0;
      rd     <= 1'b0;
      tgt    <= 8'h00;
      cmd_nv <= 1'b0;
      idle   <= '0;
      ldc    <= '0;
      ld_val <= 8'h00;
    end else begin
      if (ldc != '0) ldc <= ldc - LW'(1);
      if (frame_done) begin
        idle <= '0;
        case (eff)
          S_CMD: begin
            st <= S_CMD;
            if (sr != 8'h00) begin
              rd     <= !sr[6];
              cmd_nv <= sr[7];
              cnt    <= sr[5:0];
              st     <= S_ADDR;
              ld_val <= 8'hCC;
              ldc    <= LW'(LOAD_DLY);
            end
          end
          S_ADDR: begin
            tgt    <= sr;
            st     <= S_DATA;
            ld_val <= 8'hBB;
            ldc    <= LW'(LOAD_DLY);
          end
          default: begin
            if (cnt == 6'd0) st <= S_CMD;
            else begin
              cnt <= cnt_m1;
              if (rd) begin
                ld_val <= rd_byte;
                ldc    <= LW'(LOAD_DLY);
              end
            end
          end
        endcase
      end else if (!tmo) begin
        idle <= idle + IW'(1);
      end
    end
  end

  // writable object
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RW_BYTES; i++) mem[i] <= 8'h00;
    end else if (frame_done && eff == S_DATA && cnt != 6'd0 && !rd && tgt == RW_ADDR) begin
      for (int i = 0; i < RW_BYTES; i++)
        if (cnt_m1 == 6'(i)) mem[i] <= sr;
    end
  end

  // R2
  zero_cmd_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && eff == S_CMD && sr == 8'h00) |=> (st == S_CMD && ldc == '0));
  // R4
  addr_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && eff == S_ADDR) |=> (st == S_DATA && ld_val == 8'hBB));
  // R7
  zero_count_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && eff == S_DATA && cnt == 6'd0) |=> st == S_CMD);
  // R10
  coll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && busy) |=> wr_coll);
  // R10
  coll_keep_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && bitcnt != 3'd0 && !fall) |=> $stable(sr));
  // R11
  clean_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !busy && !frame_done) |=> (!wr_coll && !xfer_flag && sr == $past(ld_val)));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int IDLE = 400;
  localparam int H    = 6;
  localparam int GAP  = 10;
  localparam logic [31:0] RO = 32'hA4A3A2A1;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, frame_done, xfer_flag, wr_coll, cmd_nv;

  always #2.5 clk = ~clk;

  spi_reg_slave #(.IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ro_data(RO), .frame_done(frame_done), .xfer_flag(xfer_flag),
    .wr_coll(wr_coll), .cmd_nv(cmd_nv));

  int tests = 0, fails = 0, nframes = 0, pulses = 0, dbl = 0;
  bit fd_prev = 1'b0;

  // behavioural reference state
  int         m_st = 0, m_cnt = 0;
  bit         m_rd = 0, m_tmo = 0, m_nv = 0;
  logic [7:0] m_addr = 0, m_tx = 0;
  logic [7:0] m_mem [8];

  always @(negedge clk) if (rst_n) begin
    if (frame_done) pulses++;
    if (frame_done && fd_prev) dbl++;
    fd_prev = frame_done;
  end

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a, input int off);
    if (a == 8'h01 && off < 4) return RO[off*8 +: 8];
    if (a == 8'h04 && off < 8) return m_mem[off];
    return 8'h00;
  endfunction

  task automatic model_step(input logic [7:0] rx);
    if (m_tmo) m_st = 0;
    m_tmo = 0;
    case (m_st)
      0: if (rx != 0) begin
           m_rd = !rx[6]; m_nv = rx[7]; m_cnt = int'(rx[5:0]); m_st = 1; m_tx = 8'hCC;
         end else m_tx = rx;
      1: begin m_addr = rx; m_st = 2; m_tx = 8'hBB; end
      default: if (m_cnt == 0) begin m_st = 0; m_tx = rx; end
               else begin
                 m_cnt--;
                 if (m_rd) m_tx = m_read(m_addr, m_cnt);
                 else begin
                   if (m_addr == 8'h04 && m_cnt < 8) m_mem[m_cnt] = rx;
                   m_tx = rx;
                 end
               end
    endcase
  endtask

  task automatic frame(input logic [7:0] out, input string tag);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      mosi = out[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1; got[i] = miso;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (GAP) @(negedge clk);
    check(got, m_tx, tag);
    model_step(out);
    nframes++;
  endtask

  task automatic fast_frame(input logic [7:0] out);
    for (int i = 7; i >= 0; i--) begin
      mosi = out[i]; sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    model_step(out);
    nframes++;
  endtask

  task automatic go_idle();
    repeat (IDLE + 50) @(negedge clk);
    m_tmo = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1
    check({3'b0, miso, frame_done, xfer_flag, wr_coll, cmd_nv}, 8'h00, "R1 reset outputs");
    rst_n = 1'b1; cs_n = 1'b0;
    repeat (3) @(negedge clk);

    frame(8'h00, "R2 first poll");
    check({7'b0, xfer_flag}, 8'h01, "R11 flag held without load");
    frame(8'h00, "R2 zero command echoed");
    frame(8'h04, "R2 echo before command");
    check({7'b0, xfer_flag}, 8'h00, "R11 flag cleared by ack load");
    check({7'b0, cmd_nv}, 8'h00, "R12 space bit clear");
    frame(8'h01, "R3 ack CC");
    frame(8'h00, "R4 ack BB");
    frame(8'h00, "R5 ro offset 3");
    frame(8'h00, "R5 ro offset 2");
    frame(8'h00, "R5 ro offset 1");
    frame(8'h00, "R7 ro offset 0 then exit");
    frame(8'h00, "R7 back in command echo");

    // write three bytes, back to front
    frame(8'h43, "R2 echo");
    frame(8'h04, "R3 ack write");
    frame(8'h11, "R4 ack BB");
    frame(8'h22, "R6 echo data");
    frame(8'h33, "R6 echo data");
    frame(8'h00, "R6 echo data");
    frame(8'h83, "R2 echo");
    check({7'b0, cmd_nv}, 8'h01, "R12 space bit set");
    frame(8'h04, "R3 ack read");
    frame(8'h00, "R4 ack BB");
    frame(8'h00, "R6 readback 2");
    frame(8'h00, "R6 readback 1");
    frame(8'h00, "R6 readback 0");

    // count zero
    frame(8'h40, "R7 echo");
    frame(8'h04, "R7 ack");
    frame(8'h77, "R7 ack BB");
    frame(8'h02, "R7 zero count consumed");
    frame(8'h04, "R7 command after zero count");
    frame(8'h00, "R4 ack BB");
    frame(8'h00, "R7 mem1 unchanged");
    frame(8'h00, "R7 mem0 unchanged");

    // write to read-only object, then read it
    frame(8'h42, "R8 echo");
    frame(8'h01, "R8 ack");
    frame(8'h55, "R8 ack BB");
    frame(8'h66, "R8 echo");
    frame(8'h00, "R8 echo");
    frame(8'h02, "R8 echo");
    frame(8'h01, "R8 ack");
    frame(8'h00, "R8 ack BB");
    frame(8'h00, "R8 ro byte1 intact");
    frame(8'h00, "R8 ro byte0 intact");

    // unknown address
    frame(8'h02, "R8 echo");
    frame(8'h09, "R8 ack");
    frame(8'h00, "R8 ack BB");
    frame(8'h00, "R8 unknown reads zero");
    frame(8'h00, "R8 unknown reads zero");

    // overlong write and read
    frame(8'h4A, "R8 echo");
    frame(8'h04, "R8 ack");
    for (int i = 0; i < 10; i++) frame(8'hB0 + 8'(i), "R8 long write");
    frame(8'h00, "R8 echo");
    frame(8'h0A, "R8 echo");
    frame(8'h04, "R8 ack");
    for (int i = 0; i < 11; i++) frame(8'h00, "R8 long read");

    // idle timeout from the data phase
    frame(8'h02, "R9 echo");
    frame(8'h04, "R9 ack");
    frame(8'h00, "R9 ack BB");
    go_idle();
    frame(8'h01, "R9 data before timeout");
    frame(8'h04, "R9 ack after timeout");
    frame(8'h00, "R9 ack BB");
    frame(8'h00, "R9 read byte");
    frame(8'h00, "R9 exit");

    // collision: two frames back to back at full rate
    fast_frame(8'h02);
    fast_frame(8'h33);
    check({7'b0, wr_coll}, 8'h01, "R10 collision flagged");
    repeat (12) @(negedge clk);
    check({6'b0, wr_coll, xfer_flag}, 8'h00, "R11 clean load clears flags");
    go_idle();
    frame(8'h00, "R10 BB after collision");
    frame(8'h00, "R9 resync echo");

    // R13
    check(8'(dbl), 8'h00, "R13 no double pulse");
    check(8'(pulses), 8'(nframes), "R13 one pulse per frame");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule